// File: doc/BRIEF.md
# Biased Pattern Generator

This block produces test patterns in which each output bit is 1 with a probability chosen for that bit, not the fixed one half that a plain shift-register generator gives. A deep AND cone with eight unbiased inputs yields a 1 only once in 256 patterns, so a stuck-at-0 on its output is almost never exposed. Biasing those inputs toward 1 makes that fault cheap to detect. Each output bit takes a 3-bit weight code. The code selects a probability of 1/2^k or 1 - 1/2^k. The first comes from ANDing k bits of a 32-bit maximal-length LFSR. The second is the complement of that AND.

A small table holds several weight sets. A set is a full row of codes, one code per output bit. Writes to the table are accepted only while the generator is not running. A run starts with a one-cycle `start` pulse. It then emits one pattern per clock. It walks the sets from 0 up to a chosen last set and spends a chosen number of patterns on each. After the final pattern it raises `done` and waits.

The controller has three states. `S_IDLE` is the state after reset. `S_RUN` emits patterns. `S_DONE` follows the last pattern. The transitions are named as follows:
- GO: `S_IDLE` to `S_RUN` on `start`.
- NEXT: `S_RUN` stays in `S_RUN` and moves to the following set.
- FIN: `S_RUN` to `S_DONE` after the final pattern of the last set.
- AGAIN: `S_DONE` to `S_RUN` on `start`.

Top module: `biased_pattern_gen`

## Requirements
- R1: After reset the outputs are as follows: `pattern_valid` is 0, `done` is 0, `pattern` is all zeros and `pattern_set` is 0. No pattern is strobed until a `start` pulse arrives.
- R2: The internal generator is 32 bits wide. It steps once per emitted pattern as `s_next = {s[30:0], s[31]^s[21]^s[1]^s[0]}`. Every `start` accepted in S_IDLE or S_DONE reloads it with the seed 32'hACE1_2B57, and the first pattern of a run is formed from the seed itself.
- R3: Output bit j is formed from generator bits g = s[4j+3:4j], using the 3-bit weight code for that bit:
  - code 0 gives g0&g1&g2&g3 (probability 1/16);
  - code 1 gives g0&g1&g2 (1/8);
  - code 2 gives g0&g1 (1/4);
  - code 3 gives g0 (1/2);
  - code 4 gives ~(g0&g1) (3/4);
  - code 5 gives ~(g0&g1&g2) (7/8);
  - code 6 gives ~(g0&g1&g2&g3) (15/16);
  - code 7 gives ~g0 (1/2).
- R4: The table holds NUM_SETS weight sets. A pulse on `wt_wr` while the generator is not running writes `wt_codes` into set `wt_set`. Within `wt_codes`, bits [3j+2:3j] are the code for output bit j. At reset every code in every set is 3.
- R5: `start` latches `pats_per_set` and `last_set`. The run then strobes `pattern_valid` on consecutive cycles. It emits `pats_per_set` patterns with set 0, then the same number with set 1, and so on through set `last_set`. `pattern_set` gives the set used for each pattern.
- R6: `done` rises in the same cycle as the strobe of the final pattern and stays high with `pattern_valid` low until the next `start`. In the cycle after an accepted `start`, `done` is 0.
- R7: While a run is in progress, `wt_wr` and `start` are ignored. The patterns of that run use the table contents it began with.
- R8: A `pats_per_set` value of 0 is treated as 1.
- R9: The generator state is never all zeros.
- R10: A run started again from S_DONE with the same settings repeats the same pattern sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle run request |
| wt_wr | input | 1 | Weight-set write strobe |
| wt_set | input | SET_W | Weight set to write |
| wt_codes | input | 3*N_OUT | Codes for every output bit, 3 bits per bit |
| pats_per_set | input | CNT_W | Patterns spent on each set |
| last_set | input | SET_W | Index of the final set in a run |
| pattern | output | N_OUT | Weighted test pattern |
| pattern_valid | output | 1 | Pattern strobe |
| pattern_set | output | SET_W | Set that produced the current pattern |
| done | output | 1 | Run finished |

## Verification
Two events can fall on the same edge: the final pattern strobe and the rise of `done`. A set change can also coincide with a pattern being emitted. The scoreboard tags each expected pattern with its set and a last-pattern flag, and it demands `done` equal to that flag on every strobe. A further hazard arises when a table write and a second `start` hit the generator while it runs. The bench issues both in the first cycles of a run that later reaches the written set. The expected patterns are built from the old table, so any effect of the write shows up as a mismatch.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } bpg_state_e;

    localparam int CODE_W   = 3;
    localparam int GROUP_W  = 4;
    localparam int LFSR_W   = 32;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 32'h8020_0003;
    localparam logic [CODE_W-1:0] CODE_HALF = 3'd3;

    // Bias one output bit from a four-bit group of generator state.
    function automatic logic shape_bit(input logic [CODE_W-1:0] code,
                                       input logic [GROUP_W-1:0] grp);
        logic and1, and2, and3, and4;
        logic r;
        and1 = grp[0];
        and2 = &grp[1:0];
        and3 = &grp[2:0];
        and4 = &grp[3:0];
        unique case (code)
            3'd0: r = and4;
            3'd1: r = and3;
            3'd2: r = and2;
            3'd3: r = and1;
            3'd4: r = ~and2;
            3'd5: r = ~and3;
            3'd6: r = ~and4;
            3'd7: r = ~and1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bpg_lfsr.sv
module bpg_lfsr
    import bpg_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 32'hACE1_2B57
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    output logic [LFSR_W-1:0] state
);

    logic fb;

    assign fb = ^(state & LFSR_TAPS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED;
        end else if (load) begin
            state <= SEED;
        end else if (step) begin
            state <= {state[LFSR_W-2:0], fb};
        end
    end

    // R9: maximal-length register never falls into the lock-up state
    p_never_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);

    // R2: state only moves on a step or reload
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(state));

endmodule

// File: rtl/bpg_wtable.sv
module bpg_wtable
    import bpg_pkg::*;
#(
    parameter int N_OUT    = 8,
    parameter int NUM_SETS = 4,
    parameter int SET_W    = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lock,
    input  logic                    wr,
    input  logic [SET_W-1:0]        wr_set,
    input  logic [N_OUT*CODE_W-1:0] wr_codes,
    input  logic [SET_W-1:0]        rd_set,
    output logic [N_OUT*CODE_W-1:0] rd_codes
);

    localparam int ROW_W = N_OUT * CODE_W;

    logic [NUM_SETS-1:0][ROW_W-1:0] mem;

    generate
        for (genvar s = 0; s < NUM_SETS; s++) begin : g_row
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[s] <= {N_OUT{CODE_HALF}};
                end else if (wr && !lock && (wr_set == SET_W'(s))) begin
                    mem[s] <= wr_codes;
                end
            end
        end
    endgenerate

    assign rd_codes = mem[rd_set];

    // R7: table contents frozen while a run holds the lock
    p_locked_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(mem));

endmodule

// File: rtl/bpg_shaper.sv
module bpg_shaper
    import bpg_pkg::*;
#(
    parameter int N_OUT = 8
) (
    input  logic [N_OUT*GROUP_W-1:0] src,
    input  logic [N_OUT*CODE_W-1:0]  codes,
    output logic [N_OUT-1:0]         bits
);

    generate
        for (genvar j = 0; j < N_OUT; j++) begin : g_bit
            assign bits[j] = shape_bit(codes[j*CODE_W +: CODE_W],
                                       src[j*GROUP_W +: GROUP_W]);
        end
    endgenerate

endmodule

// File: rtl/biased_pattern_gen.sv
module biased_pattern_gen
    import bpg_pkg::*;
#(
    parameter int N_OUT    = 8,
    parameter int NUM_SETS = 4,
    parameter int CNT_W    = 16,
    parameter logic [LFSR_W-1:0] SEED = 32'hACE1_2B57,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int ROW_W   = N_OUT * CODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             wt_wr,
    input  logic [SET_W-1:0] wt_set,
    input  logic [ROW_W-1:0] wt_codes,
    input  logic [CNT_W-1:0] pats_per_set,
    input  logic [SET_W-1:0] last_set,
    output logic [N_OUT-1:0] pattern,
    output logic             pattern_valid,
    output logic [SET_W-1:0] pattern_set,
    output logic             done
);

    localparam int SRC_W = N_OUT * GROUP_W;

    bpg_state_e        state, state_nx;
    logic              go, adv, fin;
    logic [SET_W-1:0]  cur_set, last_q;
    logic [CNT_W-1:0]  cnt, lim;
    logic [LFSR_W-1:0] gen;
    logic [ROW_W-1:0]  codes;
    logic [N_OUT-1:0]  shaped;
    logic              running;

    assign running = (state == S_RUN);

    // Next-state and transition decode: GO, NEXT, FIN, AGAIN
    always_comb begin
        state_nx = state;
        go  = 1'b0;
        adv = 1'b0;
        fin = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    state_nx = S_RUN;
                    go = 1'b1;
                end
            end
            S_RUN: begin
                if (cnt == lim) begin
                    if (cur_set == last_q) begin
                        state_nx = S_DONE;
                        fin = 1'b1;
                    end else begin
                        adv = 1'b1;
                    end
                end
            end
            S_DONE: begin
                if (start) begin
                    state_nx = S_RUN;
                    go = 1'b1;
                end
            end
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Pattern counter and set pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_set <= '0;
            last_q  <= '0;
            cnt     <= '0;
            lim     <= '0;
        end else if (go) begin
            cur_set <= '0;
            last_q  <= last_set;
            cnt     <= '0;
            lim     <= (pats_per_set == '0) ? '0 : pats_per_set - 1'b1;
        end else if (running) begin
            if (cnt == lim) begin
                cnt <= '0;
                if (adv) cur_set <= cur_set + 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    bpg_lfsr #(.SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (go),
        .step  (running),
        .state (gen)
    );

    bpg_wtable #(.N_OUT(N_OUT), .NUM_SETS(NUM_SETS), .SET_W(SET_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock     (running),
        .wr       (wt_wr),
        .wr_set   (wt_set),
        .wr_codes (wt_codes),
        .rd_set   (cur_set),
        .rd_codes (codes)
    );

    bpg_shaper #(.N_OUT(N_OUT)) u_shp (
        .src   (gen[SRC_W-1:0]),
        .codes (codes),
        .bits  (shaped)
    );

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pattern       <= '0;
            pattern_valid <= 1'b0;
            pattern_set   <= '0;
        end else begin
            pattern_valid <= running;
            pattern       <= running ? shaped : '0;
            if (running) pattern_set <= cur_set;
        end
    end

    assign done = (state == S_DONE);

    // R6: once finished, no further strobes
    p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !pattern_valid);

    // R5: set index moves up by at most one between adjacent patterns
    p_set_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pattern_valid && $past(pattern_valid)) |->
            (pattern_set == $past(pattern_set) ||
             pattern_set == $past(pattern_set) + 1'b1));

    // R5: counter stays inside the latched window
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt <= lim));

    // R1: no strobe follows an idle cycle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |=> !pattern_valid);

    // R8: a latched count of zero behaves as one
    p_zero_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (go && pats_per_set == '0) |=> (lim == '0));

endmodule

// File: tb/sim_biased_pattern_gen.sv
`timescale 1ns/1ps
module sim_biased_pattern_gen;

    localparam int N  = 8;
    localparam int NS = 4;
    localparam int SW = 2;
    localparam int CW = 16;
    localparam logic [31:0] SEED = 32'hACE1_2B57;

    typedef struct packed {
        logic [N-1:0]  pat;
        logic [SW-1:0] set;
        logic          last;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic wt_wr = 1'b0;
    logic [SW-1:0] wt_set = '0;
    logic [N*3-1:0] wt_codes = '0;
    logic [CW-1:0] pats_per_set = '0;
    logic [SW-1:0] last_set = '0;
    logic [N-1:0] pattern;
    logic pattern_valid;
    logic [SW-1:0] pattern_set;
    logic done;

    int n_chk = 0;
    int n_bad = 0;
    exp_t q[$];
    logic [N*3-1:0] tb_tbl [NS];

    always #2 clk = ~clk;

    biased_pattern_gen #(.N_OUT(N), .NUM_SETS(NS), .CNT_W(CW), .SEED(SEED)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .wt_wr(wt_wr),
        .wt_set(wt_set), .wt_codes(wt_codes), .pats_per_set(pats_per_set),
        .last_set(last_set), .pattern(pattern), .pattern_valid(pattern_valid),
        .pattern_set(pattern_set), .done(done)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] step_gen(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic logic wbit(input logic [2:0] c, input logic [3:0] g);
        int k;
        logic r;
        k = (c < 3'd4) ? 4 - int'(c) : ((c == 3'd7) ? 1 : int'(c) - 2);
        r = 1'b1;
        for (int i = 0; i < k; i++) r &= g[i];
        return (c >= 3'd4) ? ~r : r;
    endfunction

    function automatic logic [N-1:0] model_pat(input logic [31:0] s,
                                               input logic [N*3-1:0] row);
        logic [N-1:0] p;
        for (int j = 0; j < N; j++) p[j] = wbit(row[3*j +: 3], s[4*j +: 4]);
        return p;
    endfunction

    // Monitor: compares every strobe against the scoreboard queue (R2,R3,R5,R6)
    always @(negedge clk) begin
        if (rst_n && pattern_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R5 unexpected strobe", 64'(pattern), 64'(0));
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(pattern == e.pat, "R3 pattern", 64'(pattern), 64'(e.pat));
                chk(pattern_set == e.set, "R5 set tag", 64'(pattern_set), 64'(e.set));
                chk(done == e.last, "R6 done with final strobe", 64'(done), 64'(e.last));
            end
        end
    end

    task automatic write_set(input int idx, input logic [N*3-1:0] row, input bit accepted);
        wt_set = SW'(idx);
        wt_codes = row;
        wt_wr = 1'b1;
        @(posedge clk); #1;
        wt_wr = 1'b0;
        if (accepted) tb_tbl[idx] = row;
    endtask

    task automatic run_job(input int pats, input int last, input bit disturb);
        logic [31:0] s;
        int per;
        exp_t e;
        s = SEED;
        per = (pats == 0) ? 1 : pats;
        for (int st = 0; st <= last; st++) begin
            for (int p = 0; p < per; p++) begin
                e.pat = model_pat(s, tb_tbl[st]);
                e.set = SW'(st);
                e.last = (st == last) && (p == per - 1);
                q.push_back(e);
                s = step_gen(s);
            end
        end
        pats_per_set = CW'(pats);
        last_set = SW'(last);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        chk(done == 1'b0, "R6 done clears after start", 64'(done), 64'(0));
        chk(pattern_valid == 1'b0, "R2 first strobe one cycle later", 64'(pattern_valid), 64'(0));
        if (disturb) begin
            // R7: table write and extra start during a run must be ignored
            write_set(1, {N{3'd6}}, 1'b0);
            pats_per_set = CW'(1);
            last_set = '0;
            start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
        end
        while (q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
        chk(done == 1'b1, "R6 done held", 64'(done), 64'(1));
        chk(pattern_valid == 1'b0, "R6 no strobe after done", 64'(pattern_valid), 64'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'(0), 64'(1));
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [N*3-1:0] mix;
        for (int i = 0; i < NS; i++) tb_tbl[i] = {N{3'd3}};
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(pattern_valid == 1'b0, "R1 valid", 64'(pattern_valid), 64'(0));
        chk(done == 1'b0, "R1 done", 64'(done), 64'(0));
        chk(pattern == '0, "R1 pattern", 64'(pattern), 64'(0));
        chk(pattern_set == '0, "R1 set", 64'(pattern_set), 64'(0));
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        chk(pattern_valid == 1'b0, "R1 no strobe before start", 64'(pattern_valid), 64'(0));

        // R4: reset default codes (all 3) used before any write
        run_job(3, 0, 1'b0);

        // R4: program four distinct sets
        for (int j = 0; j < N; j++) mix[3*j +: 3] = 3'(j);
        write_set(0, {N{3'd0}}, 1'b1);
        write_set(1, mix, 1'b1);
        write_set(2, {N{3'd6}}, 1'b1);
        write_set(3, {N{3'd7}}, 1'b1);

        // R2 R3 R5 R6: full walk through all sets
        run_job(5, 3, 1'b0);
        // R10: restart from done repeats the sequence
        run_job(5, 3, 1'b0);
        // R7: disturbance during a run
        run_job(4, 1, 1'b1);
        // R8: zero count means one pattern per set
        run_job(0, 2, 1'b0);
        // R4: write accepted while idle in done
        write_set(0, {N{3'd4}}, 1'b1);
        run_job(300, 0, 1'b0);
        // R9 guarded by assertion; long run with biased codes
        write_set(0, {N{3'd5}}, 1'b1);
        run_job(700, 1, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule